// File: doc/BRIEF.md
# Clamp and sync pulse generator

This block turns a raw horizontal sync, which can arrive with either polarity and with no fixed relation to the pixel clock, into two timed pulses. The first is a regenerated output sync that begins at the leading edge of the incoming sync. Its width is a programmed number of pixel clocks, and its output level can be selected. The second is a clamp pulse that marks the back porch. It opens a programmed number of pixel clocks after the incoming sync ends and stays open for a programmed number of clocks.

A source select can replace the generated clamp with an external clamp input. That input passes straight through to the clamp output. All timing fields are 8 bits wide by default. The companion configuration registers are expected to load 128 for the placement, 128 for the clamp length and 32 for the sync width after reset. These values are published as constants in the package. If the incoming sync shows a new edge while a pulse is still being timed, the timing of that pulse starts over.

Top module: `hsync_clamp_gen`

## Requirements
- R1: `hs_raw` is sampled by a two-flop synchronizer. A leading edge of the polarity-normalized sync makes `hs_out` active from the third rising clock edge, counting the edge that first samples the change as the first.
- R2: With `cfg_hs_in_pol` = 1, a high level on `hs_raw` is sync-active. With `cfg_hs_in_pol` = 0, a low level is sync-active.
- R3: `hs_out` stays active for exactly `cfg_hs_width` clock cycles.
- R4: With `cfg_hs_out_pol` = 0, `hs_out` is active high and idles low. With `cfg_hs_out_pol` = 1, it is active low and idles high.
- R5: The internal clamp becomes active `cfg_clamp_place` clock cycles after the third rising edge following the sampled trailing edge of the sync. With a placement of 0, it becomes active at that third edge.
- R6: The internal clamp stays active for exactly `cfg_clamp_len` clock cycles.
- R7: A new leading edge while `hs_out` is active restarts its width count. A new trailing edge while the clamp is still waiting restarts its placement count.
- R8: A `cfg_hs_width` of 0 produces no output sync pulse. A `cfg_clamp_len` of 0 produces no clamp pulse.
- R9: With `cfg_clamp_src` = 1, `clamp_out` follows `clamp_ext` in the same cycle and the internal clamp has no effect. With `cfg_clamp_src` = 0, `clamp_out` is the internal clamp (active high).
- R10: While reset is held and just after it is released, `hs_out` is at its inactive level, and with `cfg_clamp_src` = 0 `clamp_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_raw | input | 1 | Incoming horizontal sync, asynchronous |
| clamp_ext | input | 1 | External clamp, active high |
| cfg_clamp_place | input | CNT_W | Clamp delay after the sync trailing edge, in clocks |
| cfg_clamp_len | input | CNT_W | Clamp length in clocks |
| cfg_hs_width | input | CNT_W | Output sync width in clocks |
| cfg_hs_in_pol | input | 1 | 1 = incoming sync active high, 0 = active low |
| cfg_clamp_src | input | 1 | 1 = external clamp, 0 = internal clamp |
| cfg_hs_out_pol | input | 1 | 0 = active-high output sync, 1 = active-low |
| clamp_out | output | 1 | Selected clamp |
| hs_out | output | 1 | Regenerated output sync |

## Verification
The assertions assume that the configuration fields stay constant while a pulse is being timed. They also assume that the input polarity changes only across a reset, because flipping it while running would look like a sync edge. The stimulus changes configuration only when both timers are idle, just after a clock edge. It applies reset after each change of input polarity, and it spaces sync pulses far enough apart that clamps do not overlap, except in the deliberate restart case.

// File: rtl/clampgen_pkg.sv
package clampgen_pkg;

    // Values the configuration registers are expected to load at reset
    localparam logic [7:0] PLACE_RST = 8'd128;
    localparam logic [7:0] CLEN_RST  = 8'd128;
    localparam logic [7:0] HSW_RST   = 8'd32;

    typedef enum logic [1:0] {
        PT_IDLE = 2'd0,
        PT_WAIT = 2'd1,
        PT_HOLD = 2'd2
    } pt_state_e;

endpackage

// File: rtl/cge_sync_edge.sv
module cge_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_raw,
    input  logic active_high,
    output logic lead,
    output logic trail
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } se_state_t;

    se_state_t se_d, se_q;
    logic      norm;

    // normalized: 1 means sync is active, whatever the incoming polarity
    assign norm = active_high ? se_q.chain[STAGES-1] : ~se_q.chain[STAGES-1];

    always_comb begin
        se_d       = se_q;
        se_d.chain = {se_q.chain[STAGES-2:0], sig_raw};
        se_d.prev  = norm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            // fill with the inactive level so no edge appears after reset
            se_q.chain <= {STAGES{~active_high}};
            se_q.prev  <= 1'b0;
        end else begin
            se_q <= se_d;
        end
    end

    assign lead  = norm & ~se_q.prev;
    assign trail = ~norm & se_q.prev;

endmodule

// File: rtl/cge_pulse_timer.sv
module cge_pulse_timer
    import clampgen_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] delay,
    input  logic [CNT_W-1:0] len,
    output logic             active
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        pt_state_e        st;
        logic [CNT_W-1:0] cnt;
    } pt_reg_t;

    pt_reg_t pt_d, pt_q;

    always_comb begin
        pt_d = pt_q;
        unique case (pt_q.st)
            PT_WAIT: begin
                if (pt_q.cnt == '0) begin
                    if (len == '0) begin
                        pt_d.st = PT_IDLE;
                    end else begin
                        pt_d.st  = PT_HOLD;
                        pt_d.cnt = len - ONE;
                    end
                end else begin
                    pt_d.cnt = pt_q.cnt - ONE;
                end
            end
            PT_HOLD: begin
                if (pt_q.cnt == '0) begin
                    pt_d.st = PT_IDLE;
                end else begin
                    pt_d.cnt = pt_q.cnt - ONE;
                end
            end
            default: begin
                pt_d.st = PT_IDLE;
            end
        endcase
        // a fresh edge always wins and restarts the timing
        if (start) begin
            if (delay != '0) begin
                pt_d.st  = PT_WAIT;
                pt_d.cnt = delay - ONE;
            end else if (len != '0) begin
                pt_d.st  = PT_HOLD;
                pt_d.cnt = len - ONE;
            end else begin
                pt_d.st  = PT_IDLE;
                pt_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q.st  <= PT_IDLE;
            pt_q.cnt <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    assign active = (pt_q.st == PT_HOLD);

endmodule

// File: rtl/hsync_clamp_gen.sv
module hsync_clamp_gen #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_pix,
    input  logic             rst_n,
    input  logic             hs_raw,
    input  logic             clamp_ext,
    input  logic [CNT_W-1:0] cfg_clamp_place,
    input  logic [CNT_W-1:0] cfg_clamp_len,
    input  logic [CNT_W-1:0] cfg_hs_width,
    input  logic             cfg_hs_in_pol,
    input  logic             cfg_clamp_src,
    input  logic             cfg_hs_out_pol,
    output logic             clamp_out,
    output logic             hs_out
);

    localparam int NUM_TMR   = 2;
    localparam int TMR_HS    = 0;
    localparam int TMR_CLAMP = 1;

    logic                 lead_pulse;
    logic                 trail_pulse;
    logic [NUM_TMR-1:0]   tmr_start;
    logic [NUM_TMR-1:0]   tmr_act;
    logic [CNT_W-1:0]     tmr_delay [NUM_TMR];
    logic [CNT_W-1:0]     tmr_len   [NUM_TMR];

    cge_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk_pix),
        .rst_n       (rst_n),
        .sig_raw     (hs_raw),
        .active_high (cfg_hs_in_pol),
        .lead        (lead_pulse),
        .trail       (trail_pulse)
    );

    assign tmr_start[TMR_HS]    = lead_pulse;
    assign tmr_delay[TMR_HS]    = '0;
    assign tmr_len[TMR_HS]      = cfg_hs_width;
    assign tmr_start[TMR_CLAMP] = trail_pulse;
    assign tmr_delay[TMR_CLAMP] = cfg_clamp_place;
    assign tmr_len[TMR_CLAMP]   = cfg_clamp_len;

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        cge_pulse_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk    (clk_pix),
            .rst_n  (rst_n),
            .start  (tmr_start[g]),
            .delay  (tmr_delay[g]),
            .len    (tmr_len[g]),
            .active (tmr_act[g])
        );
    end

    assign hs_out    = tmr_act[TMR_HS] ^ cfg_hs_out_pol;
    assign clamp_out = cfg_clamp_src ? clamp_ext : tmr_act[TMR_CLAMP];

endmodule

// File: rtl/cge_chk.sv
module cge_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lead,
    input logic             trail,
    input logic             hs_act,
    input logic             clamp_int,
    input logic             clamp_ext,
    input logic             clamp_out,
    input logic             cfg_clamp_src,
    input logic [CNT_W-1:0] cfg_clamp_place,
    input logic [CNT_W-1:0] cfg_clamp_len,
    input logic [CNT_W-1:0] cfg_hs_width
);

    // R1
    hs_lead_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lead && cfg_hs_width != '0) |=> hs_act);

    // R8
    hs_zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_act) |-> ($past(cfg_hs_width) != '0));

    // R8
    clamp_zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_int) |-> ($past(cfg_clamp_len) != '0));

    // R5
    clamp_no_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trail && cfg_clamp_place == '0 && cfg_clamp_len != '0) |=> clamp_int);

    // R7
    clamp_wait_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trail && cfg_clamp_place != '0) |=> !clamp_int);

    // R9
    ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clamp_src |-> (clamp_out == clamp_ext));

endmodule

bind hsync_clamp_gen cge_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk_pix),
    .rst_n           (rst_n),
    .lead            (lead_pulse),
    .trail           (trail_pulse),
    .hs_act          (tmr_act[0]),
    .clamp_int       (tmr_act[1]),
    .clamp_ext       (clamp_ext),
    .clamp_out       (clamp_out),
    .cfg_clamp_src   (cfg_clamp_src),
    .cfg_clamp_place (cfg_clamp_place),
    .cfg_clamp_len   (cfg_clamp_len),
    .cfg_hs_width    (cfg_hs_width)
);

// File: tb/sim_hsync_clamp_gen.sv
`timescale 1ns/1ps
module sim_hsync_clamp_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_raw = 1'b0;
    logic       clamp_ext = 1'b0;
    logic [7:0] cfg_clamp_place = 8'd128;
    logic [7:0] cfg_clamp_len   = 8'd128;
    logic [7:0] cfg_hs_width    = 8'd32;
    logic       cfg_hs_in_pol   = 1'b1;
    logic       cfg_clamp_src   = 1'b0;
    logic       cfg_hs_out_pol  = 1'b0;
    logic       clamp_out;
    logic       hs_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hsync_clamp_gen u0 (
        .clk_pix(clk), .rst_n(rst_n), .hs_raw(hs_raw), .clamp_ext(clamp_ext),
        .cfg_clamp_place(cfg_clamp_place), .cfg_clamp_len(cfg_clamp_len),
        .cfg_hs_width(cfg_hs_width), .cfg_hs_in_pol(cfg_hs_in_pol),
        .cfg_clamp_src(cfg_clamp_src), .cfg_hs_out_pol(cfg_hs_out_pol),
        .clamp_out(clamp_out), .hs_out(hs_out)
    );

    typedef struct {
        int    start;
        int    len;
        string tag;
    } exp_t;

    exp_t q_hs[$];
    exp_t q_cl[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    bit hs_prev = 1'b0, cl_prev = 1'b0;
    int hs_st = 0, hs_ln = 0, cl_st = 0, cl_ln = 0;
    int hs_rises = 0, cl_rises = 0;

    always @(negedge clk) begin
        bit a;
        exp_t e;
        if (!rst_n) begin
            hs_prev = 1'b0;
            cl_prev = 1'b0;
        end else begin
            a = hs_out ^ cfg_hs_out_pol;
            if (a && !hs_prev) begin hs_st = cyc; hs_ln = 0; hs_rises++; end
            if (a) hs_ln++;
            if (!a && hs_prev) begin
                if (q_hs.size() == 0) chk(1'b0, "R8 unexpected sync pulse", hs_st, -1);
                else begin
                    e = q_hs.pop_front();
                    chk(hs_st == e.start, {e.tag, " sync start"}, hs_st, e.start);
                    chk(hs_ln == e.len, {e.tag, " sync width"}, hs_ln, e.len);
                end
            end
            hs_prev = a;
            if (!cfg_clamp_src) begin
                a = clamp_out;
                if (a && !cl_prev) begin cl_st = cyc; cl_ln = 0; cl_rises++; end
                if (a) cl_ln++;
                if (!a && cl_prev) begin
                    if (q_cl.size() == 0) chk(1'b0, "R8 unexpected clamp pulse", cl_st, -1);
                    else begin
                        e = q_cl.pop_front();
                        chk(cl_st == e.start, {e.tag, " clamp start"}, cl_st, e.start);
                        chk(cl_ln == e.len, {e.tag, " clamp length"}, cl_ln, e.len);
                    end
                end
                cl_prev = a;
            end else begin
                cl_prev = 1'b0;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic do_reset();
        @(posedge clk); #1;
        rst_n  = 1'b0;
        hs_raw = ~cfg_hs_in_pol;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic set_cfg(input int place, input int clen, input int hsw,
                           input bit opol, input bit src);
        @(posedge clk); #1;
        cfg_clamp_place = 8'(place);
        cfg_clamp_len   = 8'(clen);
        cfg_hs_width    = 8'(hsw);
        cfg_hs_out_pol  = opol;
        cfg_clamp_src   = src;
    endtask

    task automatic pulse(input int w, input int gap, input string thr, input string tcl);
        int n0, n1;
        exp_t e;
        @(negedge clk);
        n0 = cyc;
        hs_raw = cfg_hs_in_pol;
        if (cfg_hs_width != 0) begin
            e.start = n0 + 3; e.len = int'(cfg_hs_width); e.tag = thr;
            q_hs.push_back(e);
        end
        repeat (w) @(negedge clk);
        n1 = cyc;
        hs_raw = ~cfg_hs_in_pol;
        if (cfg_clamp_len != 0 && !cfg_clamp_src) begin
            e.start = n1 + 3 + int'(cfg_clamp_place); e.len = int'(cfg_clamp_len); e.tag = tcl;
            q_cl.push_back(e);
        end
        repeat (gap) @(negedge clk);
    endtask

    task automatic drained(input string req);
        chk(q_hs.size() == 0, {req, " sync queue drained"}, q_hs.size(), 0);
        chk(q_cl.size() == 0, {req, " clamp queue drained"}, q_cl.size(), 0);
    endtask

    // ---------------- sequence ----------------
    initial begin
        exp_t e;
        int n0, r0, c0;
        do_reset();
        @(negedge clk);
        // R10 reset state
        chk(hs_out == 1'b0, "R10 hs_out idle after reset", hs_out, 0);
        chk(clamp_out == 1'b0, "R10 clamp_out idle after reset", clamp_out, 0);

        // R1 R3 R5 R6 with reset-default timing values
        pulse(40, 300, "R1/R3", "R5/R6");
        drained("R3");

        // R5 zero placement, short lengths
        set_cfg(0, 5, 7, 1'b0, 1'b0);
        pulse(3, 30, "R3", "R5");
        pulse(12, 30, "R3", "R6");
        set_cfg(9, 1, 1, 1'b0, 1'b0);
        pulse(2, 30, "R3", "R6");
        drained("R6");

        // R2 active-low input
        cfg_hs_in_pol = 1'b0;
        do_reset();
        set_cfg(4, 6, 10, 1'b0, 1'b0);
        pulse(8, 40, "R2", "R2");
        drained("R2");
        cfg_hs_in_pol = 1'b1;
        do_reset();

        // R4 active-low output
        set_cfg(3, 4, 6, 1'b1, 1'b0);
        @(negedge clk);
        chk(hs_out == 1'b1, "R4 idle level with inverted output", hs_out, 1);
        pulse(5, 30, "R4", "R5");
        drained("R4");
        set_cfg(3, 4, 6, 1'b0, 1'b0);

        // R7 restart: two sync pulses ten clocks apart
        set_cfg(20, 3, 20, 1'b0, 1'b0);
        @(negedge clk);
        n0 = cyc;
        hs_raw = 1'b1;
        repeat (4) @(negedge clk);
        hs_raw = 1'b0;
        repeat (6) @(negedge clk);
        hs_raw = 1'b1;
        repeat (4) @(negedge clk);
        hs_raw = 1'b0;
        e.start = n0 + 3;  e.len = 30; e.tag = "R7"; q_hs.push_back(e);
        e.start = n0 + 37; e.len = 3;  e.tag = "R7"; q_cl.push_back(e);
        repeat (60) @(negedge clk);
        drained("R7");

        // R8 zero length
        set_cfg(2, 0, 0, 1'b0, 1'b0);
        r0 = hs_rises; c0 = cl_rises;
        pulse(10, 40, "R8", "R8");
        chk(hs_rises == r0, "R8 no sync pulse at width 0", hs_rises - r0, 0);
        chk(cl_rises == c0, "R8 no clamp pulse at length 0", cl_rises - c0, 0);

        // R9 external clamp source
        set_cfg(0, 6, 4, 1'b0, 1'b1);
        fork
            pulse(3, 30, "R9", "R9");
            for (int i = 0; i < 12; i++) begin
                @(posedge clk); #1;
                clamp_ext = (i % 3) == 1;
                #2;
                chk(clamp_out == clamp_ext, "R9 external clamp passes through", clamp_out, clamp_ext);
            end
        join
        @(posedge clk); #1;
        clamp_ext = 1'b1;
        cfg_clamp_src = 1'b0;
        #2;
        chk(clamp_out == 1'b0, "R9 internal source ignores external clamp", clamp_out, 0);
        clamp_ext = 1'b0;
        repeat (10) @(negedge clk);
        drained("R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule